// File: doc/BRIEF.md
# USB Electrical Test-Mode and Forced-Host Controller

This block holds one 8-bit control register for a USB 2.0 controller and acts on it. Software writes the register to pin the controller into the host role, pick a bus speed, ask for an endpoint 0 FIFO loopback copy, or start one of four electrical compliance test modes. The block turns those bits into a host/device role, a two-bit speed code, a line-drive request, a NAK handshake strobe, a one-cycle FIFO copy request and a replay address into a 64-byte packet buffer. It also provides a device-control status byte that carries the PHY disconnect level while the host role is forced.

The forced host role is latched. It ignores the cable ID, disconnect and line-state inputs and lasts until the session flag drops. If the force bit is still set, the role is taken again when the next session starts. The test modes are resolved by a fixed priority. While a packet is being replayed, a new mode is accepted only at the packet wrap, so every packet goes out whole.

Top module: `usb_testmode_ctrl`

## Requirements
- R1: After reset, the register reads 0x00. A write stores all eight bits: 7 force host, 6 FIFO copy, 5 full-speed select, 4 high-speed select, 3 packet test, 2 K test, 1 J test, 0 SE0/NAK test. The read port shows the stored value from the cycle after the write edge.
- R2: A write with bit 6 set raises fifoCopyReq for exactly the one cycle after the write edge. At the next edge bit 6 clears itself, unless that edge writes the register again.
- R3: While sessionValid is high and bit 7 is set, hostRole is high from the next edge onward, whatever the values of cableId, hostDiscon and lineState.
- R4: Once forced, hostRole stays high for as long as sessionValid stays high, even if bit 7 is cleared or hostDiscon rises. One edge after sessionValid falls, the forced role ends. It is taken again in the next session if bit 7 is set.
- R5: Outside the forced role, hostRole is the registered value of sessionValid AND NOT cableId AND NOT hostDiscon. A cableId of 0 marks the A side.
- R6: devCtlStatus bit 7 equals hostDiscon while the forced role is active and is 0 otherwise. Bit 2 equals hostRole, bits 1:0 equal lineState, and all other bits are 0.
- R7: speedCode resets to 01. It is loaded with {bit 4, bit 5} at the edge where the forced role begins, or at an edge where usbResetStrobe is high and the role is not forced. The codes are 00 low, 01 full and 10 high speed; the undefined 11 is loaded as 10.
- R8: lineDrive is 0 idle, 1 continuous J, 2 continuous K and 3 packet replay. When several test bits are set, the priority order is bit 3, then bit 2, then bit 1, then bit 0.
- R9: While SE0/NAK mode is active, speedCode reads 10 and nakStrobe equals inTokenValid in the same cycle. In every other mode nakStrobe is 0.
- R10: In packet mode, replayAddr starts at 0 and counts up once per cycle to 52, then wraps to 0. packetBoundary is high in exactly the cycles where replayAddr is 52. Outside packet mode, both outputs are 0.
- R11: When no packet is running, the mode picked by the register takes effect one edge after the register changes. While a packet is running, a new mode takes effect only at the wrap edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data |
| sessionValid | input | 1 | Session active flag |
| cableId | input | 1 | Cable ID level, 0 = A side |
| hostDiscon | input | 1 | PHY disconnect status |
| lineState | input | 2 | PHY line state |
| usbResetStrobe | input | 1 | Bus reset received |
| inTokenValid | input | 1 | Valid IN token seen |
| hostRole | output | 1 | 1 = host role |
| speedCode | output | 2 | Operating speed code |
| lineDrive | output | 2 | Line drive request |
| nakStrobe | output | 1 | Answer the current IN token with NAK |
| fifoCopyReq | output | 1 | Endpoint 0 TX-to-RX copy request |
| replayAddr | output | 6 | Test packet byte address |
| packetBoundary | output | 1 | Last byte of the test packet |
| devCtlStatus | output | 8 | Device-control status byte |

## Verification
Register contents, hostRole, speedCode, lineDrive, fifoCopyReq and replayAddr are registered, so each of them answers a stimulus one rising edge later. In packet mode, a requested mode change waits until the edge after the cycle in which replayAddr reads 52. nakStrobe, packetBoundary, devCtlStatus and the SE0/NAK speed override are decoded combinationally, so they follow their inputs within the same cycle. The bench changes inputs only after a falling edge. At each falling edge it first advances a behavioural model with the inputs that were applied at the preceding rising edge, then compares every output against that model, so each result is checked in the cycle it is due.

// File: rtl/utm_pkg.sv
package utm_pkg;

  localparam int BIT_FHOST = 7;
  localparam int BIT_FIFO  = 6;
  localparam int BIT_FS    = 5;
  localparam int BIT_HS    = 4;
  localparam int BIT_PKT   = 3;
  localparam int BIT_K     = 2;
  localparam int BIT_J     = 1;
  localparam int BIT_SE0   = 0;

  typedef enum logic [2:0] {
    MODE_NONE   = 3'd0,
    MODE_SE0NAK = 3'd1,
    MODE_J      = 3'd2,
    MODE_K      = 3'd3,
    MODE_PKT    = 3'd4
  } testMode_e;

  localparam logic [1:0] LD_IDLE = 2'd0;
  localparam logic [1:0] LD_J    = 2'd1;
  localparam logic [1:0] LD_K    = 2'd2;
  localparam logic [1:0] LD_PKT  = 2'd3;

  localparam logic [1:0] SPD_FULL = 2'b01;
  localparam logic [1:0] SPD_HIGH = 2'b10;

  // strobes from control to datapath
  typedef struct packed {
    testMode_e  reqMode;
    logic       loadSpeed;
    logic [1:0] speedSel;
  } ctrlStrb_t;

  function automatic logic [1:0] mapSpeed(input logic [1:0] raw);
    return (raw == 2'b11) ? SPD_HIGH : raw;
  endfunction

endpackage

// File: rtl/utm_ctrl.sv
module utm_ctrl
  import utm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  input  logic       sessionValid,
  input  logic       cableId,
  input  logic       hostDiscon,
  input  logic [1:0] lineState,
  input  logic       usbResetStrobe,
  output logic [7:0] regQ,
  output logic       hostRole,
  output logic       fifoCopyReq,
  output logic [7:0] devCtlStatus,
  output ctrlStrb_t  strb
);

  logic forcedQ;
  logic autoHostQ;
  logic fifoReqQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regQ      <= '0;
      fifoReqQ  <= 1'b0;
      forcedQ   <= 1'b0;
      autoHostQ <= 1'b0;
    end else begin
      if (regWrEn) regQ <= regWrData;
      else         regQ[BIT_FIFO] <= 1'b0;
      fifoReqQ  <= regWrEn & regWrData[BIT_FIFO];
      forcedQ   <= sessionValid & (forcedQ | regQ[BIT_FHOST]);
      autoHostQ <= sessionValid & ~cableId & ~hostDiscon;
    end
  end

  assign hostRole    = forcedQ | autoHostQ;
  assign fifoCopyReq = fifoReqQ;

  always_comb begin
    devCtlStatus      = '0;
    devCtlStatus[7]   = forcedQ & hostDiscon;
    devCtlStatus[2]   = hostRole;
    devCtlStatus[1:0] = lineState;
  end

  always_comb begin
    if (regQ[BIT_PKT])      strb.reqMode = MODE_PKT;
    else if (regQ[BIT_K])   strb.reqMode = MODE_K;
    else if (regQ[BIT_J])   strb.reqMode = MODE_J;
    else if (regQ[BIT_SE0]) strb.reqMode = MODE_SE0NAK;
    else                    strb.reqMode = MODE_NONE;
    strb.loadSpeed = ~forcedQ & ((sessionValid & regQ[BIT_FHOST]) | usbResetStrobe);
    strb.speedSel  = {regQ[BIT_HS], regQ[BIT_FS]};
  end

  // R2
  fifo_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoCopyReq |-> $past(regWrEn && regWrData[BIT_FIFO]));

  // R2
  fifo_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoCopyReq && !regWrEn) |=> !regQ[BIT_FIFO]);

  // R4
  forced_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (forcedQ && sessionValid) |=> hostRole);

  // R4
  forced_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sessionValid |=> !devCtlStatus[7]);

endmodule

// File: rtl/utm_datapath.sv
module utm_datapath
  import utm_pkg::*;
#(
  parameter int BUF_DEPTH = 64,
  parameter int PKT_LEN   = 53,
  localparam int ADDR_W   = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic              inTokenValid,
  output logic [1:0]        speedCode,
  output logic [1:0]        lineDrive,
  output logic              nakStrobe,
  output logic [ADDR_W-1:0] replayAddr,
  output logic              packetBoundary
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(PKT_LEN - 1);

  testMode_e         modeQ;
  logic [ADDR_W-1:0] addrQ;
  logic [1:0]        speedQ;
  logic              inPkt;
  logic              atWrap;

  assign inPkt  = (modeQ == MODE_PKT);
  assign atWrap = inPkt && (addrQ == LAST_ADDR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ  <= MODE_NONE;
      addrQ  <= '0;
      speedQ <= SPD_FULL;
    end else begin
      if (strb.loadSpeed) speedQ <= mapSpeed(strb.speedSel);
      if (inPkt && !atWrap) begin
        addrQ <= addrQ + 1'b1;
      end else begin
        modeQ <= strb.reqMode;
        addrQ <= '0;
      end
    end
  end

  always_comb begin
    case (modeQ)
      MODE_PKT: lineDrive = LD_PKT;
      MODE_K:   lineDrive = LD_K;
      MODE_J:   lineDrive = LD_J;
      default:  lineDrive = LD_IDLE;
    endcase
  end

  assign speedCode      = (modeQ == MODE_SE0NAK) ? SPD_HIGH : speedQ;
  assign nakStrobe      = (modeQ == MODE_SE0NAK) & inTokenValid;
  assign replayAddr     = addrQ;
  assign packetBoundary = atWrap;

  // R10
  addr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    replayAddr <= LAST_ADDR);

  // R10
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    packetBoundary |=> (replayAddr == '0));

  // R11
  pkt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inPkt && !packetBoundary) |=> (lineDrive == LD_PKT && replayAddr == $past(replayAddr) + 1'b1));

  // R7
  speed_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    speedQ != 2'b11);

endmodule

// File: rtl/usb_testmode_ctrl.sv
module usb_testmode_ctrl
  import utm_pkg::*;
#(
  parameter int BUF_DEPTH = 64,
  parameter int PKT_LEN   = 53,
  localparam int ADDR_W   = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              sessionValid,
  input  logic              cableId,
  input  logic              hostDiscon,
  input  logic [1:0]        lineState,
  input  logic              usbResetStrobe,
  input  logic              inTokenValid,
  output logic              hostRole,
  output logic [1:0]        speedCode,
  output logic [1:0]        lineDrive,
  output logic              nakStrobe,
  output logic              fifoCopyReq,
  output logic [ADDR_W-1:0] replayAddr,
  output logic              packetBoundary,
  output logic [7:0]        devCtlStatus
);

  ctrlStrb_t strb;

  utm_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .regWrEn        (regWrEn),
    .regWrData      (regWrData),
    .sessionValid   (sessionValid),
    .cableId        (cableId),
    .hostDiscon     (hostDiscon),
    .lineState      (lineState),
    .usbResetStrobe (usbResetStrobe),
    .regQ           (regRdData),
    .hostRole       (hostRole),
    .fifoCopyReq    (fifoCopyReq),
    .devCtlStatus   (devCtlStatus),
    .strb           (strb)
  );

  utm_datapath #(
    .BUF_DEPTH (BUF_DEPTH),
    .PKT_LEN   (PKT_LEN)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strb           (strb),
    .inTokenValid   (inTokenValid),
    .speedCode      (speedCode),
    .lineDrive      (lineDrive),
    .nakStrobe      (nakStrobe),
    .replayAddr     (replayAddr),
    .packetBoundary (packetBoundary)
  );

endmodule

// File: tb/usb_testmode_ctrl_tb.sv
`timescale 1ns/1ps
module usb_testmode_ctrl_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic       sessionValid = 1'b0, cableId = 1'b1, hostDiscon = 1'b0;
  logic [1:0] lineState = '0;
  logic       usbResetStrobe = 1'b0, inTokenValid = 1'b0;
  logic [7:0] regRdData, devCtlStatus;
  logic       hostRole, nakStrobe, fifoCopyReq, packetBoundary;
  logic [1:0] speedCode, lineDrive;
  logic [5:0] replayAddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural reference state
  int mReg = 0, mForced = 0, mAuto = 0, mSpeed = 1, mMode = 0, mAddr = 0, mFifo = 0;

  always #2 clk = ~clk;

  usb_testmode_ctrl u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .sessionValid(sessionValid), .cableId(cableId),
    .hostDiscon(hostDiscon), .lineState(lineState), .usbResetStrobe(usbResetStrobe),
    .inTokenValid(inTokenValid), .hostRole(hostRole), .speedCode(speedCode),
    .lineDrive(lineDrive), .nakStrobe(nakStrobe), .fifoCopyReq(fifoCopyReq),
    .replayAddr(replayAddr), .packetBoundary(packetBoundary), .devCtlStatus(devCtlStatus)
  );

  function automatic int speedOf(int r);
    int raw = ((r >> 4) & 1) * 2 + ((r >> 5) & 1);
    return (raw == 3) ? 2 : raw;
  endfunction

  task automatic stepModel();
    int req, nf;
    if (!rstN) begin
      mReg = 0; mForced = 0; mAuto = 0; mSpeed = 1; mMode = 0; mAddr = 0; mFifo = 0;
      return;
    end
    if (mReg[3]) req = 4; else if (mReg[2]) req = 3; else if (mReg[1]) req = 2;
    else if (mReg[0]) req = 1; else req = 0;
    nf = (sessionValid && (mForced != 0 || mReg[7])) ? 1 : 0;
    if (mForced == 0 && ((sessionValid && mReg[7]) || usbResetStrobe)) mSpeed = speedOf(mReg);
    mForced = nf;
    mAuto = (sessionValid && !cableId && !hostDiscon) ? 1 : 0;
    if (mMode == 4 && mAddr != 52) mAddr++;
    else begin mMode = req; mAddr = 0; end
    if (regWrEn) begin mReg = regWrData; mFifo = regWrData[6]; end
    else begin mReg = mReg & 8'hBF; mFifo = 0; end
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  task automatic compareAll();
    int host = (mForced != 0 || mAuto != 0) ? 1 : 0;
    int ld = (mMode == 4) ? 3 : (mMode == 3) ? 2 : (mMode == 2) ? 1 : 0;
    int dc = ((mForced != 0 && hostDiscon) ? 128 : 0) + host * 4 + int'(lineState);
    chk("R1 R2 register", int'(regRdData), mReg);
    chk("R2 fifoCopyReq", int'(fifoCopyReq), mFifo);
    chk("R3 R4 R5 hostRole", int'(hostRole), host);
    chk("R6 devCtlStatus", int'(devCtlStatus), dc);
    chk("R7 R9 speedCode", int'(speedCode), (mMode == 1) ? 2 : mSpeed);
    chk("R8 R11 lineDrive", int'(lineDrive), ld);
    chk("R9 nakStrobe", int'(nakStrobe), (mMode == 1 && inTokenValid) ? 1 : 0);
    chk("R10 R11 replayAddr", int'(replayAddr), (mMode == 4) ? mAddr : 0);
    chk("R10 packetBoundary", int'(packetBoundary), (mMode == 4 && mAddr == 52) ? 1 : 0);
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      stepModel();
      compareAll();
      regWrEn = 1'b0;
      usbResetStrobe = 1'b0;
    end
  endtask

  task automatic wr(logic [7:0] d);
    regWrEn = 1'b1; regWrData = d; tick();
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    tick(3);                                   // R1 reset state
    rstN = 1'b1; tick(2);
    // R7 speed selection on bus reset, 11 maps to high
    wr(8'h30); usbResetStrobe = 1'b1; tick(2);
    wr(8'h20); usbResetStrobe = 1'b1; tick(2);
    wr(8'h00); usbResetStrobe = 1'b1; tick(2);
    // R5 automatic role
    cableId = 1'b0; sessionValid = 1'b1; tick(3);
    hostDiscon = 1'b1; tick(2); hostDiscon = 1'b0; tick(2);
    cableId = 1'b1; tick(2); sessionValid = 1'b0; tick(2);
    // R3 R4 R6 forced role
    wr(8'h90); tick(); sessionValid = 1'b1; lineState = 2'b10; tick(3);
    hostDiscon = 1'b1; tick(2); wr(8'h00); usbResetStrobe = 1'b1; tick(3);
    hostDiscon = 1'b0; sessionValid = 1'b0; tick(2);
    sessionValid = 1'b1; tick(3); sessionValid = 1'b0; tick();
    wr(8'hA0); sessionValid = 1'b1; tick(3); sessionValid = 1'b0; tick(2);
    // R2 FIFO copy
    wr(8'h40); tick(2); wr(8'h41); wr(8'h41); tick(2);
    // R8 R9 test modes and priority
    wr(8'h02); tick(3); wr(8'h06); tick(3); wr(8'h01); tick();
    inTokenValid = 1'b1; tick(2); inTokenValid = 1'b0; tick(2);
    // R10 R11 packet replay and deferred change
    wr(8'h0F); tick(20); wr(8'h04); tick(50); wr(8'h08); tick(120);
    wr(8'h00); tick(60);
    // mixed traffic
    for (int c = 0; c < 3000; c++) begin
      sessionValid   = ($urandom % 16) != 0 ? sessionValid : ~sessionValid;
      cableId        = $urandom % 2;
      hostDiscon     = ($urandom % 8) == 0;
      lineState      = 2'($urandom);
      inTokenValid   = $urandom % 2;
      usbResetStrobe = ($urandom % 20) == 0;
      if (($urandom % 25) == 0) begin regWrEn = 1'b1; regWrData = 8'($urandom); end
      tick();
    end
    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

endmodule